// File: doc/BRIEF.md
# Dual PWM and Toggle Timer

This block is a counter of two equal halves that runs either as two independent channels or as one double-width counter. It drives two waveform outputs, one for the low half and one for the high half. Each output is either a toggle square wave or a PWM wave, chosen by a 2-bit mode input. Each half also raises a one-cycle overflow pulse. In split modes each half counts from zero up to its own period value. In joined modes the two halves form one counter whose period is the concatenation of the high and low period inputs. In that case the low half still gives a carry toggle or a byte-wide PWM.

Counting advances on a count-tick input, or on rising edges of an external event input, whichever is selected. Period and duty inputs are copied into internal shadow copies only at a period boundary. Software can therefore rewrite them at any time without cutting a pulse short.

Top module: `dual_tmr`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, both waveform outputs and both overflow pulses are low.
- R2: With `useEvt` low, every clock edge with `tickEn` high is one advance. With `useEvt` high, an advance is a clock edge at which `evtIn` is high after being low at the previous edge, and `tickEn` is ignored.
- R3: All shadow copies are zero after reset and after a mode change. The first advance after either one is therefore a period boundary, which loads the shadows and, in a toggle mode, flips the output.
- R4: In mode 2'b00 each half counts 0 up to its shadow period P. The advance taken at P returns the count to 0 and flips that half's output, so the output flips every P+1 advances.
- R5: An overflow output is high for exactly the one cycle after each boundary event of its half. In split modes this is the half's own period restart. In joined modes `hiOvf` marks the full-width restart and `loOvf` marks each carry of the low byte from all-ones to zero.
- R6: In mode 2'b01 each output is high while its half's count is below its shadow duty. This makes the output rise at the period restart. A duty of 0 keeps the output low, and a duty above the period keeps it high.
- R7: A new period or duty value takes effect only at the next boundary of its half. The current period finishes with the old values.
- R8: In mode 2'b10 the counter is `{high,low}` with period `{hiPer,loPer}`. `hiOut` flips at each full-width restart, and `loOut` flips on each carry of the low byte.
- R9: In mode 2'b11 `hiOut` behaves as in R8. `loOut` is high while the low byte is below the low shadow duty, and that shadow reloads at each low-byte carry and at each full-width restart.
- R10: At the first clock edge where `mode` differs from its value at the previous edge, both counters, all shadows, both toggle states and both overflow pulses are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 split toggle, 01 split PWM, 10 joined toggle, 11 joined toggle with low PWM |
| tickEn | input | 1 | Count tick, used when `useEvt` is low |
| useEvt | input | 1 | Selects the external event as the advance source |
| evtIn | input | 1 | External event, synchronous to `clk` |
| loPer | input | W | Low half period (low byte of the joined period) |
| hiPer | input | W | High half period (high byte of the joined period) |
| loDuty | input | W | Low half PWM duty |
| hiDuty | input | W | High half PWM duty |
| loOut | output | 1 | Low channel waveform |
| hiOut | output | 1 | High channel waveform |
| loOvf | output | 1 | Low half overflow pulse |
| hiOvf | output | 1 | High half overflow pulse |

## Verification
The assertions assume that `mode` changes only on purpose and then stays put for at least two cycles. They also assume that `evtIn` is already synchronous to `clk`, and that no advance and no mode change happen together with reset release. The stimulus drives every input at the falling edge and changes `mode` only while the tick is held low. It also holds each event level for several cycles, so each pulse counts as exactly one advance.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT_TGL = 2'b00,
    MODE_SPLIT_PWM = 2'b01,
    MODE_WIDE_TGL  = 2'b10,
    MODE_WIDE_PWM  = 2'b11
  } tmrMode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAll;
    logic loClr;
    logic loInc;
    logic hiClr;
    logic hiInc;
    logic loEvt;
    logic hiEvt;
    logic loPerLd;
    logic hiPerLd;
    logic loDutyLd;
    logic hiDutyLd;
    logic loPwm;
    logic hiPwm;
  } tmrStrobe_t;

  // compare results from datapath back to control
  typedef struct packed {
    logic loAtPer;
    logic hiAtPer;
    logic loFull;
  } tmrFlag_t;

endpackage

// File: rtl/dual_tmr_half.sv
module dual_tmr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         cntClr,
  input  logic         cntInc,
  input  logic         evt,
  input  logic         perLd,
  input  logic         dutyLd,
  input  logic         pwmSel,
  input  logic [W-1:0] perIn,
  input  logic [W-1:0] dutyIn,
  output logic         atPer,
  output logic         full,
  output logic         wave,
  output logic         ovf
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] perSh;
  logic [W-1:0] dutySh;
  logic         tgl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= ZERO;
      perSh  <= ZERO;
      dutySh <= ZERO;
      tgl    <= 1'b0;
      ovf    <= 1'b0;
    end else if (clr) begin
      cnt    <= ZERO;
      perSh  <= ZERO;
      dutySh <= ZERO;
      tgl    <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (cntClr)      cnt <= ZERO;
      else if (cntInc) cnt <= cnt + ONE;
      if (perLd)  perSh  <= perIn;
      if (dutyLd) dutySh <= dutyIn;
      if (evt && !pwmSel) tgl <= ~tgl;
      ovf <= evt;
    end
  end

  assign atPer = (cnt == perSh);
  assign full  = &cnt;
  assign wave  = pwmSel ? (cnt < dutySh) : tgl;

endmodule

// File: rtl/dual_tmr_ctrl.sv
module dual_tmr_ctrl
  import dual_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       tickEn,
  input  logic       useEvt,
  input  logic       evtIn,
  input  tmrFlag_t   flags,
  output tmrStrobe_t stb
);
  tmrMode_e   modeE;
  logic [1:0] modePrev;
  logic       evtPrev;
  logic       adv;
  logic       wideWrap;
  logic       lowCarry;

  assign modeE = tmrMode_e'(mode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev <= 2'b00;
      evtPrev  <= 1'b0;
    end else begin
      modePrev <= mode;
      evtPrev  <= evtIn;
    end
  end

  assign adv      = useEvt ? (evtIn & ~evtPrev) : tickEn;
  assign wideWrap = adv & flags.loAtPer & flags.hiAtPer;
  assign lowCarry = adv & flags.loFull & ~wideWrap;

  always_comb begin
    stb        = '0;
    stb.clrAll = (mode != modePrev);
    stb.loPwm  = (modeE == MODE_SPLIT_PWM) || (modeE == MODE_WIDE_PWM);
    stb.hiPwm  = (modeE == MODE_SPLIT_PWM);
    if (!mode[1]) begin
      // two independent halves
      stb.loClr    = adv & flags.loAtPer;
      stb.loInc    = adv & ~flags.loAtPer;
      stb.hiClr    = adv & flags.hiAtPer;
      stb.hiInc    = adv & ~flags.hiAtPer;
      stb.loEvt    = stb.loClr;
      stb.hiEvt    = stb.hiClr;
      stb.loPerLd  = stb.loClr;
      stb.loDutyLd = stb.loClr;
      stb.hiPerLd  = stb.hiClr;
      stb.hiDutyLd = stb.hiClr;
    end else begin
      // one counter of double width
      stb.loClr    = wideWrap;
      stb.loInc    = adv & ~wideWrap;
      stb.hiClr    = wideWrap;
      stb.hiInc    = lowCarry;
      stb.loEvt    = lowCarry;
      stb.hiEvt    = wideWrap;
      stb.loPerLd  = wideWrap;
      stb.hiPerLd  = wideWrap;
      stb.loDutyLd = wideWrap | lowCarry;
      stb.hiDutyLd = wideWrap;
    end
  end

endmodule

// File: rtl/dual_tmr_dp.sv
module dual_tmr_dp
  import dual_tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   stb,
  input  logic [W-1:0] loPer,
  input  logic [W-1:0] hiPer,
  input  logic [W-1:0] loDuty,
  input  logic [W-1:0] hiDuty,
  output tmrFlag_t     flags,
  output logic         loOut,
  output logic         hiOut,
  output logic         loOvf,
  output logic         hiOvf
);
  localparam int HALVES = 2;

  logic [HALVES-1:0]        cClr, cInc, ev, pLd, dLd, pw;
  logic [HALVES-1:0]        atPer, full, wave, ovf;
  logic [HALVES-1:0][W-1:0] perArr, dutyArr;

  assign cClr    = {stb.hiClr,    stb.loClr};
  assign cInc    = {stb.hiInc,    stb.loInc};
  assign ev      = {stb.hiEvt,    stb.loEvt};
  assign pLd     = {stb.hiPerLd,  stb.loPerLd};
  assign dLd     = {stb.hiDutyLd, stb.loDutyLd};
  assign pw      = {stb.hiPwm,    stb.loPwm};
  assign perArr  = {hiPer,  loPer};
  assign dutyArr = {hiDuty, loDuty};

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    dual_tmr_half #(.W(W)) half_i (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (stb.clrAll),
      .cntClr (cClr[g]),
      .cntInc (cInc[g]),
      .evt    (ev[g]),
      .perLd  (pLd[g]),
      .dutyLd (dLd[g]),
      .pwmSel (pw[g]),
      .perIn  (perArr[g]),
      .dutyIn (dutyArr[g]),
      .atPer  (atPer[g]),
      .full   (full[g]),
      .wave   (wave[g]),
      .ovf    (ovf[g])
    );
  end

  assign flags.loAtPer = atPer[0];
  assign flags.hiAtPer = atPer[1];
  assign flags.loFull  = full[0];
  assign loOut = wave[0];
  assign hiOut = wave[1];
  assign loOvf = ovf[0];
  assign hiOvf = ovf[1];

  logic unusedHiFull;
  assign unusedHiFull = full[1];

endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import dual_tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   mode,
  input  logic         tickEn,
  input  logic         useEvt,
  input  logic         evtIn,
  input  logic [W-1:0] loPer,
  input  logic [W-1:0] hiPer,
  input  logic [W-1:0] loDuty,
  input  logic [W-1:0] hiDuty,
  output logic         loOut,
  output logic         hiOut,
  output logic         loOvf,
  output logic         hiOvf
);
  tmrStrobe_t stb;
  tmrFlag_t   flags;

  dual_tmr_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .tickEn (tickEn),
    .useEvt (useEvt),
    .evtIn  (evtIn),
    .flags  (flags),
    .stb    (stb)
  );

  dual_tmr_dp #(.W(W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .loPer  (loPer),
    .hiPer  (hiPer),
    .loDuty (loDuty),
    .hiDuty (hiDuty),
    .flags  (flags),
    .loOut  (loOut),
    .hiOut  (hiOut),
    .loOvf  (loOvf),
    .hiOvf  (hiOvf)
  );

endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       tickEn,
  input logic       useEvt,
  input logic       loOut,
  input logic       hiOut,
  input logic       loOvf,
  input logic       hiOvf
);
  // R1: registers are cleared one edge after reset is seen
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!loOut && !hiOut && !loOvf && !hiOvf));

  // R2: no advance source, no overflow
  p_idle_no_ovf_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(useEvt) && !$past(tickEn)) |-> (!loOvf && !hiOvf));

  // R4: in split toggle mode the low output only moves with its overflow
  p_lo_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode, 2) == 2'b00 && $past(mode) == 2'b00 && mode == 2'b00 && !$stable(loOut))
      |-> loOvf);

  // R8: in joined toggle mode the high output only moves with its overflow
  p_hi_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode, 2) == 2'b10 && $past(mode) == 2'b10 && mode == 2'b10 && !$stable(hiOut))
      |-> hiOvf);

  // R10: a mode change clears outputs and pulses at the next edge
  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |=> (!loOut && !hiOut && !loOvf && !hiOvf));

endmodule

bind dual_tmr dual_tmr_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .mode   (mode),
  .tickEn (tickEn),
  .useEvt (useEvt),
  .loOut  (loOut),
  .hiOut  (hiOut),
  .loOvf  (loOvf),
  .hiOvf  (hiOvf)
);

// File: tb/dual_tmr_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         tickEn = 1'b0;
  logic         useEvt = 1'b0;
  logic         evtIn = 1'b0;
  logic [W-1:0] loPer = '0;
  logic [W-1:0] hiPer = '0;
  logic [W-1:0] loDuty = '0;
  logic [W-1:0] hiDuty = '0;
  logic         loOut, hiOut, loOvf, hiOvf;

  int nChecks = 0;
  int nErrors = 0;
  int nLoTg, nHiTg, nLoOvf, nHiOvf, nLoHigh, nHiHigh;

  always #5 clk = ~clk;

  dual_tmr #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .tickEn(tickEn), .useEvt(useEvt),
    .evtIn(evtIn), .loPer(loPer), .hiPer(hiPer), .loDuty(loDuty),
    .hiDuty(hiDuty), .loOut(loOut), .hiOut(hiOut), .loOvf(loOvf), .hiOvf(hiOvf)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearTally();
    nLoTg = 0; nHiTg = 0; nLoOvf = 0; nHiOvf = 0; nLoHigh = 0; nHiHigh = 0;
  endtask

  // advance n edges, sampling each result at the falling edge
  task automatic run(input int n);
    logic pl, ph;
    pl = loOut; ph = hiOut;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (loOut != pl) nLoTg++;
      if (hiOut != ph) nHiTg++;
      nLoOvf  += int'(loOvf);
      nHiOvf  += int'(hiOvf);
      nLoHigh += int'(loOut);
      nHiHigh += int'(hiOut);
      pl = loOut; ph = hiOut;
    end
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0; mode = m; tickEn = 1'b0; useEvt = 1'b0; evtIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);  // idle edge: any start-up mode clear lands here
  endtask

  task automatic prime();
    tickEn = 1'b1;
    run(1);
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 loOut in reset", loOut, 0);
    check("R1 hiOut in reset", hiOut, 0);
    check("R1 loOvf in reset", loOvf, 0);
    check("R1 hiOvf in reset", hiOvf, 0);
    doReset(2'b00);
    check("R1 outputs after release", {loOut, hiOut, loOvf, hiOvf}, 0);
  endtask

  task automatic tSplitToggle();
    loPer = 8'd3; hiPer = 8'd1;
    doReset(2'b00);
    prime();
    check("R3 first advance flips loOut", loOut, 1);
    check("R3 first advance flips hiOut", hiOut, 1);
    clearTally();
    run(16);
    tickEn = 1'b0;
    check("R4 lo toggles period 3", nLoTg, 4);
    check("R4 hi toggles period 1", nHiTg, 8);
    check("R5 lo overflow pulses", nLoOvf, 4);
    check("R5 hi overflow pulses", nHiOvf, 8);
  endtask

  task automatic tSplitPwm();
    loPer = 8'd4; loDuty = 8'd2; hiPer = 8'd3; hiDuty = 8'd0;
    doReset(2'b01);
    prime();
    clearTally();
    run(20);
    tickEn = 1'b0;
    check("R6 lo PWM high cycles", nLoHigh, 8);
    check("R6 hi duty zero stays low", nHiHigh, 0);
    check("R5 lo PWM overflows", nLoOvf, 4);
    check("R5 hi PWM overflows", nHiOvf, 5);
    hiDuty = 8'd9;
    doReset(2'b01);
    prime();
    clearTally();
    run(12);
    tickEn = 1'b0;
    check("R6 hi duty above period stays high", nHiHigh, 12);
  endtask

  task automatic tUpdate();
    loPer = 8'd4; loDuty = 8'd2;
    doReset(2'b01);
    prime();
    run(2);
    check("R6 lo low at count 2", loOut, 0);
    loDuty = 8'd5;
    run(1);
    check("R7 old duty kept at count 3", loOut, 0);
    run(1);
    check("R7 old duty kept at count 4", loOut, 0);
    run(1);
    check("R7 new duty at restart", loOut, 1);
    run(4);
    tickEn = 1'b0;
    check("R7 new duty at count 4", loOut, 1);
  endtask

  task automatic tModeChange();
    loPer = 8'd3; hiPer = 8'd1;
    doReset(2'b00);
    prime();
    tickEn = 1'b0;
    mode = 2'b10;
    clearTally();
    run(1);
    check("R10 loOut cleared", loOut, 0);
    check("R10 hiOut cleared", hiOut, 0);
    check("R10 pulses cleared", nLoOvf + nHiOvf, 0);
    run(2);
    tickEn = 1'b1;
    run(1);
    tickEn = 1'b0;
    check("R3 boundary after mode change hiOut", hiOut, 1);
    check("R3 boundary after mode change loOut", loOut, 0);
  endtask

  task automatic tWideToggle();
    loPer = 8'h02; hiPer = 8'h01;
    doReset(2'b10);
    prime();
    clearTally();
    run(518);
    tickEn = 1'b0;
    check("R8 hi toggles at 16-bit restart", nHiTg, 2);
    check("R8 lo toggles on byte carry", nLoTg, 2);
    check("R5 joined hi overflows", nHiOvf, 2);
    check("R5 joined lo carries", nLoOvf, 2);
  endtask

  task automatic tWidePwm();
    loPer = 8'h00; hiPer = 8'h02; loDuty = 8'h40;
    doReset(2'b11);
    prime();
    clearTally();
    run(513);
    tickEn = 1'b0;
    check("R9 lo byte PWM high cycles", nLoHigh, 129);
    check("R9 hi toggles once", nHiTg, 1);
    check("R9 hi overflow", nHiOvf, 1);
    check("R9 lo carries", nLoOvf, 2);
  endtask

  task automatic pulse();
    evtIn = 1'b1; run(3);
    evtIn = 1'b0; run(3);
  endtask

  task automatic tEvent();
    loPer = 8'd1; hiPer = 8'd0;
    doReset(2'b00);
    useEvt = 1'b1; tickEn = 1'b1;
    clearTally();
    run(5);
    check("R2 tick ignored in event mode", nLoTg + nHiTg + nLoOvf + nHiOvf, 0);
    pulse();
    check("R2 event primes hiOut", hiOut, 1);
    clearTally();
    repeat (4) pulse();
    check("R2 lo toggles per event pair", nLoTg, 2);
    check("R2 hi toggles per event", nHiTg, 4);
    useEvt = 1'b0; tickEn = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    tReset();
    tSplitToggle();
    tSplitPwm();
    tUpdate();
    tModeChange();
    tWideToggle();
    tWidePwm();
    tEvent();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule